// File: doc/BRIEF.md
# Auto-Reload Timer / Event Counter

This block is an 8-bit down-counter with automatic reload, used as the timer peripheral of a small low-power controller. Each count step comes either from a one-cycle tick supplied by an external prescaler or from an edge on an external input pin. The pin can be taken raw or through a debouncer, and either its rising or its falling edge can be chosen. The debouncer samples the pin on one of two sample-tick inputs, one slow and one fast, as picked by a control bit.

Software talks to the block through a small register bus. A write to the reload address sets the reload value. If the counter is stopped, the same write also loads the counter. A read of that address returns the live count. A control register holds the enable, source, edge, debounce and sample-rate selections and the interrupt mask. When a step lands the count at zero, the counter reloads and sets a request flag. The flag is set whatever the mask says. The `irq` output is the flag gated by the mask. Reading the flag address returns the flag and clears it.

Top module: `tmr_evcnt`

## Requirements
- R1: After reset the count, reload value, control register and request flag all read as zero, and `irq` is low.
- R2: A write to address 0 stores the reload value. While the enable bit is 0, the same write also loads the count. While the enable bit is 1, the count is left untouched and the new value is used at the next reload.
- R3: While the enable bit (control bit 0) is 0, count steps are ignored and the count holds.
- R4: With the source bit (control bit 1) at 0, each `pre_tick` pulse of one cycle lowers the count by one. Pin activity has no effect in this mode.
- R5: A step taken when the count is 1, or when it is 0, loads the reload value and sets the request flag. The flag therefore sets once every `reload` steps, and a reload of 0 behaves like a reload of 1.
- R6: The request flag sets whether or not the mask bit (control bit 5) is 1. `irq` is high exactly when both the flag and the mask are 1.
- R7: A read of address 2 returns the flag in bit 0 and clears it. If a zero event happens in the same cycle as the read, the flag stays set.
- R8: With the source bit at 1, `pre_tick` is ignored. Each selected pin edge takes one step: the rising edge when the edge bit (control bit 2) is 0, the falling edge when it is 1.
- R9: With the raw bit (control bit 3) at 1, the synchronised pin feeds the edge detector directly, so a high pulse of one cycle counts. With the raw bit at 0, a new pin level is taken only after two equal consecutive samples, so such a pulse does not count.
- R10: The debouncer samples on `deb_fast_tick` when the rate bit (control bit 4) is 1 and on `deb_slow_tick` when it is 0. Without a tick on the selected input, its level does not change.
- R11: A read of address 0 returns the live count, and a read of address 1 returns the control register as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_tick | input | 1 | Prescaler tap, one-cycle pulse per count step |
| pin_in | input | 1 | External event pin, asynchronous |
| deb_slow_tick | input | 1 | Slow debouncer sample enable |
| deb_fast_tick | input | 1 | Fast debouncer sample enable |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Write address: 0 reload, 1 control |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Bus read strobe (a read of address 2 clears the flag) |
| rd_addr | input | 2 | Read address: 0 count, 1 control, 2 flag |
| rd_data | output | 8 | Read data, combinational |
| irq | output | 1 | Masked interrupt request |

## Verification
Reload values 0 through 9 are swept with prescaler steps. After every step the count and the flag are compared with an arithmetic model, which separates the decrement path from the reload path and shows that 0 and 1 are handled alike at the terminal count. The pin source is driven with long pulses, which tell the two edge polarities apart by the moment of the step. It is also driven with one-cycle glitches, which tell the raw path from the debounced one. Sample-tick patterns, with the selected rate input held silent and then active, separate the two debouncer rates. A flag read that coincides with a zero event, and reload writes made while counting and while stopped, cover the ordering cases.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Control register layout, MSB first: mask, fast, raw, fall, src_pin, en
  typedef struct packed {
    logic mask;
    logic fast;
    logic raw;
    logic fall;
    logic src_pin;
    logic en;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

endpackage

// File: rtl/tmr_debounce.sv
module tmr_debounce (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_i,
  input  logic din_i,
  output logic level_o
);

  logic last_q, last_d;
  logic level_q, level_d;

  always_comb begin
    last_d  = last_q;
    level_d = level_q;
    if (sample_i) begin
      last_d = din_i;
      if (din_i == last_q) level_d = din_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= 1'b0;
      level_q <= 1'b0;
    end else begin
      last_q  <= last_d;
      level_q <= level_d;
    end
  end

  assign level_o = level_q;

  AST_DEB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> $stable(level_q)); // R10

endmodule

// File: rtl/tmr_pin_event.sv
module tmr_pin_event #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic slow_tick_i,
  input  logic fast_tick_i,
  input  logic fast_sel_i,
  input  logic raw_sel_i,
  input  logic fall_sel_i,
  output logic evt_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_sync;
  logic                   deb_level;
  logic                   deb_sample;
  logic                   sel_lvl;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign pin_sync   = sync_q[SYNC_STAGES-1];
  assign deb_sample = fast_sel_i ? fast_tick_i : slow_tick_i;

  tmr_debounce u_deb (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (deb_sample),
    .din_i    (pin_sync),
    .level_o  (deb_level)
  );

  assign sel_lvl = raw_sel_i ? pin_sync : deb_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sel_lvl;
  end

  assign evt_o = fall_sel_i ? (prev_q & ~sel_lvl) : (sel_lvl & ~prev_q);

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o); // R8

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             load_wr_i,
  input  logic [CNT_W-1:0] load_data_i,
  input  logic             flag_rd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rld_q, rld_d;
  logic             flag_q, flag_d;
  logic             step;
  logic             zero_evt;

  assign step     = tick_i & en_i;
  assign zero_evt = step & (cnt_q <= ONE);

  always_comb begin
    rld_d = rld_q;
    cnt_d = cnt_q;
    if (load_wr_i) rld_d = load_data_i;
    if (zero_evt)              cnt_d = rld_q;
    else if (step)             cnt_d = cnt_q - ONE;
    else if (load_wr_i && !en_i) cnt_d = load_data_i;
  end

  always_comb begin
    flag_d = flag_q;
    if (flag_rd_i) flag_d = 1'b0;
    if (zero_evt)  flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rld_q  <= rld_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !load_wr_i) |=> $stable(cnt_q)); // R3
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE); // R4
  AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (cnt_q == $past(rld_q)) && flag_q); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd_i && !zero_evt) |=> !flag_q); // R7

endmodule

// File: rtl/tmr_evcnt.sv
module tmr_evcnt
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_tick,
  input  logic             pin_in,
  input  logic             deb_slow_tick,
  input  logic             deb_fast_tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [BUS_W-1:0] rd_data,
  output logic             irq
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic             pin_evt;
  logic             src_tick;
  logic             load_wr;
  logic             flag_rd;
  logic [CNT_W-1:0] cnt;
  logic             flag;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && wr_addr == ADDR_CTRL) ctrl_d = tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ctrl_q <= '0;
    else            ctrl_q <= ctrl_d;
  end

  assign load_wr = wr_en & (wr_addr == ADDR_CNT);
  assign flag_rd = rd_en & (rd_addr == ADDR_FLAG);

  tmr_pin_event #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .pin_i       (pin_in),
    .slow_tick_i (deb_slow_tick),
    .fast_tick_i (deb_fast_tick),
    .fast_sel_i  (ctrl_q.fast),
    .raw_sel_i   (ctrl_q.raw),
    .fall_sel_i  (ctrl_q.fall),
    .evt_o       (pin_evt)
  );

  assign src_tick = ctrl_q.src_pin ? pin_evt : pre_tick;

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en_i        (ctrl_q.en),
    .tick_i      (src_tick),
    .load_wr_i   (load_wr),
    .load_data_i (wr_data[CNT_W-1:0]),
    .flag_rd_i   (flag_rd),
    .cnt_o       (cnt),
    .flag_o      (flag)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CNT:  rd_data = BUS_W'(cnt);
      ADDR_CTRL: rd_data = BUS_W'(ctrl_q);
      ADDR_FLAG: rd_data = BUS_W'(flag);
      default:   rd_data = '0;
    endcase
  end

  assign irq = flag & ctrl_q.mask;

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ctrl_q.mask && !(wr_en && wr_addr == ADDR_CTRL)) |=> !irq); // R6

endmodule

// File: tb/tmr_evcnt_bench.sv
module tmr_evcnt_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pre_tick, pin_in, deb_slow_tick, deb_fast_tick;
  logic       wr_en, rd_en;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       irq;

  int total = 0;
  int fail  = 0;

  always #2.5 clk = ~clk;

  tmr_evcnt u_tmr_evcnt (
    .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .pin_in(pin_in),
    .deb_slow_tick(deb_slow_tick), .deb_fast_tick(deb_fast_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // control encodings: bit0 en, bit1 pin source, bit2 falling, bit3 raw, bit4 fast, bit5 mask
  localparam logic [7:0] C_EN = 8'h01, C_SRC = 8'h02, C_FALL = 8'h04,
                         C_RAW = 8'h08, C_FAST = 8'h10, C_MASK = 8'h20;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic step();
    pre_tick = 1'b1;
    @(negedge clk);
    pre_tick = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_pulse(int n);
    pin_in = 1'b1;
    idle(n);
    pin_in = 1'b0;
    idle(6);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fail, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    logic [7:0] d;
    int exp_cnt;
    int exp_flag;
    rst_n = 1'b0; pre_tick = 0; pin_in = 0; deb_slow_tick = 0; deb_fast_tick = 0;
    wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(2'd0, d); chk("R1 count", d, 0);
    rd(2'd1, d); chk("R1 ctrl", d, 0);
    rd(2'd2, d); chk("R1 flag", d, 0);
    #1 chk("R1 irq", irq, 0);

    // R2 load while stopped, R3 steps ignored while stopped
    wr(2'd0, 8'd5);
    rd(2'd0, d); chk("R2 load stopped", d, 5);
    step(); step(); step();
    rd(2'd0, d); chk("R3 hold disabled", d, 5);

    // R2 reload write while running
    wr(2'd1, C_EN);
    step();
    rd(2'd0, d); chk("R4 decrement", d, 4);
    wr(2'd0, 8'd3);
    rd(2'd0, d); chk("R2 running write keeps count", d, 4);
    step(); step(); step(); step();
    rd(2'd0, d); chk("R2 new reload used", d, 3);
    rd(2'd2, d); chk("R5 flag after zero", d, 1);

    // R5 sweep of reload values
    for (int r = 0; r <= 9; r++) begin
      wr(2'd1, 8'h00);
      wr(2'd0, 8'(r));
      rd(2'd2, d);
      wr(2'd1, C_EN);
      exp_cnt = r;
      for (int k = 0; k < 2 * ((r > 1) ? r : 1) + 2; k++) begin
        step();
        if (exp_cnt <= 1) begin exp_cnt = r; exp_flag = 1; end
        else begin exp_cnt--; exp_flag = 0; end
        rd(2'd0, d); chk("R5 sweep count", d, exp_cnt);
        rd(2'd2, d); chk("R5 sweep flag", d, exp_flag);
      end
    end

    // R6 flag without mask, irq with mask, R7 clear
    wr(2'd1, 8'h00);
    wr(2'd0, 8'd2);
    rd(2'd2, d);
    wr(2'd1, C_EN);
    step(); step();
    #1 chk("R6 irq masked off", irq, 0);
    wr(2'd1, C_EN | C_MASK);
    #1 chk("R6 irq with mask", irq, 1);
    rd(2'd2, d); chk("R7 read returns flag", d, 1);
    #1 chk("R7 irq after clear", irq, 0);
    rd(2'd2, d); chk("R7 flag cleared", d, 0);

    // R7 read coincides with zero event
    step();
    rd_en = 1'b1; rd_addr = 2'd2; pre_tick = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0; pre_tick = 1'b0;
    chk("R7 coincident read value", d, 0);
    rd(2'd2, d); chk("R7 zero wins over clear", d, 1);
    rd(2'd0, d); chk("R11 live count", d, 2);
    rd(2'd1, d); chk("R11 ctrl readback", d, C_EN | C_MASK);

    // R8 pin source, rising then falling, prescaler ignored
    wr(2'd1, 8'h00);
    wr(2'd0, 8'd10);
    deb_fast_tick = 1'b1;
    wr(2'd1, C_EN | C_SRC | C_RAW);
    idle(4);
    step(); step();
    rd(2'd0, d); chk("R8 prescaler ignored", d, 10);
    pin_in = 1'b1; idle(5);
    rd(2'd0, d); chk("R8 rising step", d, 9);
    pin_in = 1'b0; idle(5);
    rd(2'd0, d); chk("R8 no step on fall", d, 9);
    wr(2'd1, C_EN | C_SRC | C_RAW | C_FALL);
    pin_in = 1'b1; idle(5);
    rd(2'd0, d); chk("R8 falling mode ignores rise", d, 9);
    pin_in = 1'b0; idle(5);
    rd(2'd0, d); chk("R8 falling step", d, 8);

    // R9 raw counts a glitch, debounced does not
    wr(2'd1, C_EN | C_SRC | C_RAW);
    pin_pulse(1);
    rd(2'd0, d); chk("R9 raw glitch counts", d, 7);
    wr(2'd1, C_EN | C_SRC | C_FAST);
    idle(3);
    pin_pulse(1);
    rd(2'd0, d); chk("R9 debounced glitch rejected", d, 7);
    pin_pulse(4);
    rd(2'd0, d); chk("R9 debounced pulse counts", d, 6);

    // R10 sample rate selection
    wr(2'd1, C_EN | C_SRC);
    pin_pulse(6);
    rd(2'd0, d); chk("R10 slow rate silent", d, 6);
    wr(2'd1, C_EN | C_SRC | C_FAST);
    pin_pulse(4);
    rd(2'd0, d); chk("R10 fast rate counts", d, 5);
    deb_fast_tick = 1'b0; deb_slow_tick = 1'b1;
    wr(2'd1, C_EN | C_SRC | C_FAST);
    pin_pulse(6);
    rd(2'd0, d); chk("R10 fast rate silent", d, 5);
    wr(2'd1, C_EN | C_SRC);
    pin_pulse(4);
    rd(2'd0, d); chk("R10 slow rate counts", d, 4);

    summary();
  end

endmodule